// File: doc/BRIEF.md
# Four-Channel DMA Register Bank

This block is the host-facing register file of a four-channel DMA controller. A host reaches it through a narrow byte-wide port: a 4-bit offset, a write strobe, a read strobe, a write data byte and a combinational read data byte. Each channel has a 16-bit memory address and a 16-bit transfer count. Both sit behind the byte port and are reached one byte at a time. A single shared low/high byte pointer decides which half a given access touches.

The bank also holds the per-channel mode fields, the per-channel request masks, a global disable bit and the terminal-count status flags. It exports the current address, the mode fields, the masks and a per-channel "may transfer" signal to a separate transfer engine. The engine reports each completed transfer with a one-cycle step pulse per channel. The bank then advances that channel's current address and count. When a channel runs out, the bank either reloads the channel from its programmed values or masks it, depending on the channel's auto-initialise setting.

Top module: `dma4_regbank`

## Requirements
- R1: After a synchronous active-low reset, all four masks are set, the byte pointer selects the low byte, all status flags are zero, the global disable is off, and every address, count and mode field is zero.
- R2: The byte pointer starts low after a write to offset 12 or offset 13. Every read or write at offsets 0 to 7 flips it, so the first such access hits bits 7:0 and the second hits bits 15:8.
- R3: Offset 2n holds the address of channel n and offset 2n+1 holds its count (n = 0..3). A write updates the selected byte of both the programmed copy and the current copy. A read returns the selected byte of the current copy.
- R4: A write to offset 10 sets the mask of the channel named by data bits 1:0 to the value of data bit 2. The value 1 blocks the channel.
- R5: A write to offset 15 loads mask n from data bit n for all four channels at once. A write to offset 14 clears all four masks.
- R6: A write to offset 13 returns the byte pointer to low, clears all terminal-count flags and sets all four masks. Address, count and mode contents are kept.
- R7: A write to offset 11 stores data bits 7:2 as the mode of the channel named by bits 1:0. The stored fields are: transfer type in bits 3:2, auto-initialise in bit 4, address decrement in bit 5, and service mode in bits 7:6. Channel n's stored bits appear on mode_o[6n+5:6n] in the same order.
- R8: Data bit 2 of a write to offset 8 sets the global disable. While it is set, go_o is all zero and step pulses have no effect.
- R9: go_o[n] is high exactly when dreq_i[n] is high, mask n is clear and the global disable is off.
- R10: A read of offset 8 returns the four terminal-count flags in bits 3:0 and the live dreq_i in bits 7:4. The read clears the flags, except a flag set in that same cycle.
- R11: A step pulse on a channel that is unmasked while the controller is enabled moves its current address by +1, or by -1 when the decrement bit is set. It also lowers its current count by one. A step on a masked channel is ignored.
- R12: A step taken while the current count is zero is a terminal count. The count wraps to 0xFFFF, the channel's flag sets, and tc_o pulses for one cycle after that edge. With auto-initialise set, the current address and count reload from the programmed copies. Otherwise the channel's mask sets.
- R13: Writes to offset 9 change nothing. Reads of offsets 9 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 4 | Register offset |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, valid while rd_i is high |
| dreq_i | input | 4 | Per-channel transfer request from devices |
| step_i | input | 4 | Per-channel one-transfer-done pulse from the engine |
| go_o | output | 4 | Per-channel permission to transfer |
| mask_o | output | 4 | Per-channel mask state |
| mode_o | output | 24 | Stored mode fields, 6 bits per channel |
| addr_o | output | 64 | Current address, 16 bits per channel |
| tc_o | output | 4 | Terminal-count pulse per channel |

## Verification
Byte sequencing is tried three ways: two accesses after a pointer clear, a single access followed by a read, and a clear between two writes. These show a pointer that toggles apart from one that is stuck or never cleared. Steps are applied to an incrementing auto-initialise channel and a decrementing one-shot channel. The first wraps and reloads; the second wraps and masks itself. This separates reload from mask-on-completion and shows the direction bit at work. Masks are driven through the single, multi, clear and master-reset ports and checked on go_o. Steps are also taken while masked and while globally disabled, which shows that gating blocks the address update.

// File: rtl/dma4_pkg.sv
// Shared constants for the four-channel DMA register bank.
// Assumes a 4-bit offset space; offsets below 8 are channel registers.
package dma4_pkg;
    localparam int NCH    = 4;
    localparam int OFS_W  = 4;
    localparam int MODE_W = 6;
    localparam int MB_AUTO = 2;   // auto-initialise position within stored mode
    localparam int MB_DEC  = 3;   // decrement position within stored mode

    localparam logic [OFS_W-1:0] OFS_CMD    = 4'd8;
    localparam logic [OFS_W-1:0] OFS_REQ    = 4'd9;
    localparam logic [OFS_W-1:0] OFS_SMASK  = 4'd10;
    localparam logic [OFS_W-1:0] OFS_MODE   = 4'd11;
    localparam logic [OFS_W-1:0] OFS_CLRBP  = 4'd12;
    localparam logic [OFS_W-1:0] OFS_MRESET = 4'd13;
    localparam logic [OFS_W-1:0] OFS_MCLR   = 4'd14;
    localparam logic [OFS_W-1:0] OFS_MMASK  = 4'd15;
endpackage

// File: rtl/dma4_chan.sv
// One channel's address and count registers: programmed and current copies.
// Assumes wr_addr/wr_cnt are single-cycle strobes and step is already gated
// by mask and global disable. A host write wins over a step for that register.
module dma4_chan #(
    parameter int DW = 8,
    localparam int RW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          hi,
    input  logic [DW-1:0] wdata,
    input  logic          step,
    input  logic          auto_init,
    input  logic          dec,
    output logic [RW-1:0] cur_addr,
    output logic [RW-1:0] cur_cnt,
    output logic          tc_hit
);
    logic [RW-1:0] base_addr;
    logic [RW-1:0] base_cnt;

    // Terminal count: a step taken while the count is already exhausted.
    assign tc_hit = step && (cur_cnt == '0);

    // Address register: byte load from host, else advance or reload on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_addr <= '0;
            cur_addr  <= '0;
        end else if (wr_addr) begin
            if (hi) begin
                base_addr[RW-1:DW] <= wdata;
                cur_addr[RW-1:DW]  <= wdata;
            end else begin
                base_addr[DW-1:0] <= wdata;
                cur_addr[DW-1:0]  <= wdata;
            end
        end else if (step) begin
            if (tc_hit && auto_init)
                cur_addr <= base_addr;
            else if (dec)
                cur_addr <= cur_addr - 1'b1;
            else
                cur_addr <= cur_addr + 1'b1;
        end
    end

    // Count register: byte load from host, else decrement or reload on step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_cnt <= '0;
            cur_cnt  <= '0;
        end else if (wr_cnt) begin
            if (hi) begin
                base_cnt[RW-1:DW] <= wdata;
                cur_cnt[RW-1:DW]  <= wdata;
            end else begin
                base_cnt[DW-1:0] <= wdata;
                cur_cnt[DW-1:0]  <= wdata;
            end
        end else if (step) begin
            if (tc_hit && auto_init)
                cur_cnt <= base_cnt;
            else
                cur_cnt <= cur_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/dma4_ctrl.sv
// Shared control state: byte pointer, global disable, masks, modes, flags.
// Assumes at most one of wr/rd per cycle and that tc_hit comes from the
// channels in the same cycle as the step that caused it.
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OFS_W-1:0]      addr,
    input  logic                  wr,
    input  logic                  rd,
    input  logic [DW-1:0]         wdata,
    input  logic [NCH-1:0]        tc_hit,
    output logic                  bp_hi,
    output logic                  off,
    output logic [NCH-1:0]        mask,
    output logic [NCH-1:0]        flags,
    output logic [NCH-1:0]        tc_q,
    output logic [NCH*MODE_W-1:0] mode_flat,
    output logic [NCH-1:0]        auto_vec,
    output logic [NCH-1:0]        dec_vec
);
    logic [MODE_W-1:0] modes [NCH];
    logic [NCH-1:0]    mask_host;
    logic              chan_acc;

    assign chan_acc = (wr || rd) && (addr[OFS_W-1] == 1'b0);

    // Unpack per-channel mode fields for export and for the channels.
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            mode_flat[n*MODE_W +: MODE_W] = modes[n];
            auto_vec[n] = modes[n][MB_AUTO];
            dec_vec[n]  = modes[n][MB_DEC];
        end
    end

    // Host-driven next mask before terminal-count masking is merged in.
    always_comb begin
        mask_host = mask;
        if (wr) begin
            case (addr)
                OFS_SMASK:  mask_host[wdata[1:0]] = wdata[2];
                OFS_MMASK:  mask_host = wdata[NCH-1:0];
                OFS_MCLR:   mask_host = '0;
                OFS_MRESET: mask_host = '1;
                default:    mask_host = mask;
            endcase
        end
    end

    // Byte pointer: cleared by two ports, toggled by every channel access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bp_hi <= 1'b0;
        else if (wr && (addr == OFS_CLRBP || addr == OFS_MRESET))
            bp_hi <= 1'b0;
        else if (chan_acc)
            bp_hi <= ~bp_hi;
    end

    // Global disable, mode store and mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off  <= 1'b0;
            mask <= '1;
            for (int n = 0; n < NCH; n++) modes[n] <= '0;
        end else begin
            if (wr && addr == OFS_CMD)
                off <= wdata[2];
            if (wr && addr == OFS_MODE)
                modes[wdata[1:0]] <= wdata[DW-1:2];
            mask <= mask_host | (tc_hit & ~auto_vec);
        end
    end

    // Terminal-count flags and the one-cycle terminal-count pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
            tc_q  <= '0;
        end else begin
            tc_q <= tc_hit;
            if (wr && addr == OFS_MRESET)
                flags <= '0;
            else if (rd && addr == OFS_CMD)
                flags <= tc_hit;
            else
                flags <= flags | tc_hit;
        end
    end
endmodule

// File: rtl/dma4_regbank.sv
// Top of the four-channel DMA register bank: decodes host accesses,
// instantiates one register pair per channel and builds the read mux.
// Assumes DW = 2 * channel count so the status byte fills the data bus.
module dma4_regbank
    import dma4_pkg::*;
#(
    parameter int DW = 8,
    localparam int RW = 2 * DW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OFS_W-1:0]      addr_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [DW-1:0]         wdata_i,
    output logic [DW-1:0]         rdata_o,
    input  logic [NCH-1:0]        dreq_i,
    input  logic [NCH-1:0]        step_i,
    output logic [NCH-1:0]        go_o,
    output logic [NCH-1:0]        mask_o,
    output logic [NCH*MODE_W-1:0] mode_o,
    output logic [NCH*RW-1:0]     addr_o,
    output logic [NCH-1:0]        tc_o
);
    logic           bp_hi;
    logic           off;
    logic [NCH-1:0] flags;
    logic [NCH-1:0] tc_hit;
    logic [NCH-1:0] auto_vec;
    logic [NCH-1:0] dec_vec;
    logic [NCH-1:0] step_ok;
    logic [RW-1:0]  cur_addr [NCH];
    logic [RW-1:0]  cur_cnt  [NCH];
    logic [RW-1:0]  sel_word;

    dma4_ctrl #(.DW(DW)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr_i), .wr(wr_i), .rd(rd_i),
        .wdata(wdata_i), .tc_hit(tc_hit), .bp_hi(bp_hi), .off(off),
        .mask(mask_o), .flags(flags), .tc_q(tc_o), .mode_flat(mode_o),
        .auto_vec(auto_vec), .dec_vec(dec_vec)
    );

    // Transfers are permitted only on unmasked channels of an enabled bank.
    assign go_o    = dreq_i & ~mask_o & {NCH{~off}};
    assign step_ok = step_i & ~mask_o & {NCH{~off}};

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic wr_a, wr_c;
        assign wr_a = wr_i && (addr_i == OFS_W'(2 * n));
        assign wr_c = wr_i && (addr_i == OFS_W'(2 * n + 1));

        dma4_chan #(.DW(DW)) i_chan (
            .clk(clk), .rst_n(rst_n), .wr_addr(wr_a), .wr_cnt(wr_c),
            .hi(bp_hi), .wdata(wdata_i), .step(step_ok[n]),
            .auto_init(auto_vec[n]), .dec(dec_vec[n]),
            .cur_addr(cur_addr[n]), .cur_cnt(cur_cnt[n]), .tc_hit(tc_hit[n])
        );
        assign addr_o[n*RW +: RW] = cur_addr[n];
    end

    // Read mux: channel registers by pointer, status at the command offset.
    always_comb begin
        sel_word = addr_i[0] ? cur_cnt[addr_i[2:1]] : cur_addr[addr_i[2:1]];
        if (addr_i[OFS_W-1] == 1'b0)
            rdata_o = bp_hi ? sel_word[RW-1:DW] : sel_word[DW-1:0];
        else if (addr_i == OFS_CMD)
            rdata_o = DW'({dreq_i, flags});
        else
            rdata_o = '0;
    end
endmodule

// File: rtl/dma4_regbank_chk.sv
// Protocol checker for the DMA register bank, attached by bind.
// Assumes the host never issues a mask write in the same cycle as a step.
module dma4_regbank_chk
    import dma4_pkg::*;
#(
    parameter int DW = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [OFS_W-1:0] addr_i,
    input logic             wr_i,
    input logic [DW-1:0]    wdata_i,
    input logic [NCH-1:0]   step_i,
    input logic [NCH-1:0]   go_o,
    input logic [NCH-1:0]   mask_o,
    input logic [NCH-1:0]   tc_o
);
    p_single_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_SMASK && step_i == '0)
        |=> mask_o[$past(wdata_i[1:0])] == $past(wdata_i[2]));

    p_multi_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_MMASK && step_i == '0)
        |=> mask_o == $past(wdata_i[NCH-1:0]));

    p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_MCLR && step_i == '0) |=> mask_o == '0);

    p_mreset_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_MRESET) |=> mask_o == '1);

    p_disable_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_CMD && wdata_i[2]) |=> go_o == '0);

    p_tc_after_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_o != '0) |-> ((tc_o & ~$past(step_i)) == '0));
endmodule

bind dma4_regbank dma4_regbank_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_dma4_regbank.sv
// Directed bench for the DMA register bank: one task per scenario.
module test_dma4_regbank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [3:0]  dreq_i = 4'hF;
    logic [3:0]  step_i = '0;
    logic [3:0]  go_o, mask_o, tc_o;
    logic [23:0] mode_o;
    logic [63:0] addr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dma4_regbank i_dma4_regbank (.*);

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk); addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk); wr_i = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr_i = a; rd_i = 1'b1;
        #2 d = rdata_o;
        @(negedge clk); rd_i = 1'b0;
    endtask

    task automatic step(logic [3:0] m);
        @(negedge clk); step_i = m;
        @(negedge clk); step_i = '0;
        #2;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(4'd8, d);  chk("R1 status", d, 8'hF0);
        chk("R1 mask", mask_o, 4'hF);
        chk("R1 go", go_o, 4'h0);
        chk("R1 mode", mode_o, 24'h0);
        chk("R1 addr", addr_o, 64'h0);
    endtask

    task automatic t_bytes();
        logic [7:0] d;
        wr(4'd12, 0); wr(4'd2, 8'h34); wr(4'd2, 8'h12);
        wr(4'd3, 8'h02); wr(4'd3, 8'h00);
        chk("R3 ch1 addr out", addr_o[31:16], 16'h1234);
        wr(4'd12, 0); rd(4'd3, d); chk("R3 count lo", d, 8'h02);
        rd(4'd3, d); chk("R3 count hi", d, 8'h00);
        wr(4'd12, 0); wr(4'd4, 8'hAA); rd(4'd4, d);
        chk("R2 toggle to high", d, 8'h00);
        wr(4'd12, 0); wr(4'd4, 8'h11); wr(4'd12, 0); wr(4'd4, 8'h22);
        chk("R2 clear between writes", addr_o[47:32], 16'h0022);
    endtask

    task automatic t_masks();
        wr(4'd10, 8'h01); chk("R4 unmask ch1", mask_o, 4'hD);
        wr(4'd10, 8'h05); chk("R4 mask ch1", mask_o, 4'hF);
        wr(4'd15, 8'h0A); chk("R5 multi", mask_o, 4'hA);
        wr(4'd14, 8'h00); chk("R5 clear", mask_o, 4'h0);
        #2 chk("R9 go all", go_o, 4'hF);
        dreq_i = 4'h6; #2 chk("R9 go follows dreq", go_o, 4'h6);
        dreq_i = 4'hF;
        wr(4'd8, 8'h04); chk("R8 go off", go_o, 4'h0);
        wr(4'd8, 8'h00); chk("R8 go back", go_o, 4'hF);
    endtask

    task automatic t_auto_step();
        logic [7:0] d;
        wr(4'd11, 8'h55); chk("R7 ch1 mode", mode_o[11:6], 6'h15);
        step(4'b0010); chk("R11 inc addr", addr_o[31:16], 16'h1235);
        wr(4'd12, 0); rd(4'd3, d); chk("R11 count dec", d, 8'h01);
        step(4'b0010); step(4'b0010);
        chk("R12 tc pulse", tc_o, 4'b0010);
        chk("R12 reload addr", addr_o[31:16], 16'h1234);
        chk("R12 auto keeps mask", mask_o, 4'h0);
        wr(4'd12, 0); rd(4'd3, d); chk("R12 reload count", d, 8'h02);
        rd(4'd8, d); chk("R10 status tc", d, 8'hF2);
        rd(4'd8, d); chk("R10 read clears", d, 8'hF0);
    endtask

    task automatic t_oneshot();
        logic [7:0] d;
        wr(4'd11, 8'h6A); chk("R7 ch2 mode", mode_o[17:12], 6'h1A);
        step(4'b0100);
        chk("R12 tc ch2", tc_o, 4'b0100);
        chk("R11 dec addr", addr_o[47:32], 16'h0021);
        chk("R12 one-shot masks", mask_o, 4'b0100);
        wr(4'd12, 0); rd(4'd5, d); chk("R12 wrap lo", d, 8'hFF);
        rd(4'd5, d); chk("R12 wrap hi", d, 8'hFF);
        step(4'b0100);
        chk("R11 masked step addr", addr_o[47:32], 16'h0021);
        chk("R11 masked step tc", tc_o, 4'h0);
        wr(4'd8, 8'h04); step(4'b0010);
        chk("R8 disabled step", addr_o[31:16], 16'h1234);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_mreset();
        logic [7:0] d;
        step(4'b0001); chk("R12 ch0 masks", mask_o, 4'b0101);
        wr(4'd6, 8'h99);
        dreq_i = 4'h0;
        wr(4'd13, 8'h00);
        chk("R6 masks set", mask_o, 4'hF);
        rd(4'd8, d); chk("R6 status cleared", d, 8'h00);
        wr(4'd6, 8'h77); chk("R6 pointer low", addr_o[63:48], 16'h0077);
        chk("R6 data kept", addr_o[31:16], 16'h1234);
    endtask

    task automatic t_ignored();
        logic [7:0] d;
        wr(4'd9, 8'hFF); chk("R13 request write mask", mask_o, 4'hF);
        rd(4'd9, d); chk("R13 read 9", d, 8'h00);
        rd(4'd14, d); chk("R13 read 14", d, 8'h00);
        dreq_i = 4'h5; rd(4'd8, d); chk("R10 live dreq", d, 8'h50);
        chk("R13 mode kept", mode_o, 24'h01A540);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bytes();
        t_masks();
        t_auto_step();
        t_oneshot();
        t_mreset();
        t_ignored();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule